// File: doc/BRIEF.md
# Adaptive Bus-Slave Cycle Sequencer

This block sits between a microprocessor-style expansion bus and the register file of a memory-mapped peripheral. The peripheral runs on a fast local clock that has no fixed phase relation to the bus clock. The block brings the bus clock into the local domain and recognizes its rising and falling edges. It then counts local cycles from each rising edge. At chosen counts it samples the address, the direction and the select line. For a selected access it sends a one-cycle request to the register file. For a write it samples the write data late in the cycle. For a read it drives the returned data onto the bus until the bus clock falls.

The points are not fixed. The block measures the bus period, in local cycles, from one rising edge to the next. It also notes where the last falling edge was seen. From these it computes the three points as fractions of the period, and keeps each point a guard distance ahead of the falling edge. The same design therefore serves bus clocks from about 1.0 MHz to about 1.8 MHz without any change. New points take effect only at a rising edge, so a bus cycle in progress keeps the points it started with.

Top module: `bus_slave_seq`

## Requirements
- R1: The bus clock passes through a two-flop synchronizer. An edge is recognized when the synchronized level differs from the level one local cycle earlier. The phase count is 1 in the first local cycle after a rising edge is recognized and then rises by one per cycle. A point at offset N is acted on at the clock edge where the phase count is at least N. The falling position F is the phase count at the edge where a falling edge is recognized.
- R2: The measured period P is the phase count at the edge where the next rising edge is recognized. The phase count saturates at 2^CW-1 and does not wrap. Offsets are reloaded only at a recognized rising edge, and stay constant during a bus cycle.
- R3: At each recognized rising edge after the first, the three offsets are reloaded as follows: control = floor(P*CTL_NUM/64), drive = floor(P*DRV_NUM/64) and write = floor(P*WR_NUM/64). Each is then limited to at most F-GUARD (or to 1 when F is not above GUARD) and raised to at least 1. F is taken from the bus cycle that just ended.
- R4: After reset the bus cycle that begins at the first recognized rising edge is never served. The first served cycle begins at the second rising edge. The reset offsets are derived from DEF_PERIOD with a falling position of DEF_PERIOD/2.
- R5: In a served cycle, when bus_sel=1 and bus_rd_wr_n=1 are sampled at the control point, req_valid is high for the next local cycle, with req_write=0 and req_addr equal to the sampled address.
- R6: For a read, reg_rdata is sampled in the cycle where req_valid is high. From the cycle after the phase count reaches the drive offset (and after that sample), bus_oe=1 and bus_rdata holds the sampled value. bus_oe falls in the cycle after a falling or rising edge is recognized.
- R7: In a served cycle, when bus_sel=1 and bus_rd_wr_n=0 are sampled at the control point, bus_wdata is sampled at the write point. req_valid is then high for one cycle with req_write=1, the address sampled at the control point, and the sampled data.
- R8: The bus inputs are used only at their sampling points. If bus_sel=0 at the control point, the bus cycle produces no request and no drive. If the address changes after the control point, req_addr does not change.
- R9: A falling edge recognized before a pending control, drive or write point cancels that point. The bus cycle then issues no further request and no drive.
- R10: Each bus cycle produces at most one request, and each request is exactly one local cycle wide.
- R11: While reset is active and after it is released, bus_oe=0 and req_valid=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_clk | input | 1 | Bus clock, asynchronous to clk |
| bus_addr | input | AW | Bus register address |
| bus_wdata | input | DW | Bus write data |
| bus_sel | input | 1 | Chip select, active high |
| bus_rd_wr_n | input | 1 | 1 = read, 0 = write |
| bus_rdata | output | DW | Read data toward the bus |
| bus_oe | output | 1 | Enable for the bus data driver |
| req_valid | output | 1 | One-cycle request to the register file |
| req_write | output | 1 | 1 = write request, 0 = read request |
| req_addr | output | AW | Request address |
| req_wdata | output | DW | Request write data |
| reg_rdata | input | DW | Read data returned by the register file |

## Verification
Two things can happen in the same local cycle: the falling edge is recognized, and a pending drive or write point comes due. When they meet, the falling edge must win. The bench provokes this by changing the bus timing abruptly. In one case a short bus cycle follows long ones. In another the high phase shrinks while the period stays the same. In both cases the offsets carried over from the earlier cycle reach past the new falling edge. A behavioural model runs in step with the design on every clock and judges the result. It checks that no write request appears, that the driver never turns on, and that any drive already active drops in the cycle after the falling edge is recognized.

// File: rtl/bus_slave_seq_pkg.sv
package bus_slave_seq_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_ARM   = 2'd1,
    SQ_READ  = 2'd2,
    SQ_WRITE = 2'd3
  } sq_state_e;

  // Scale a measured period by num/64, keep it GUARD cycles ahead of the
  // last falling position, never below 1.
  function automatic int unsigned place_point(int unsigned period, int unsigned num,
                                              int unsigned fall_pos, int unsigned guard);
    int unsigned raw;
    int unsigned lim;
    raw = (period * num) >> 6;
    lim = (fall_pos > guard) ? (fall_pos - guard) : 1;
    if (raw > lim) raw = lim;
    if (raw < 1) raw = 1;
    return raw;
  endfunction

endpackage

// File: rtl/bsq_edge_sync.sv
module bsq_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_o,
  output logic fall_o
);
  localparam int unsigned TOP = STAGES - 1;

  logic [TOP:0] chain_q, chain_d;
  logic         last_q;

  always_comb begin
    chain_d = {chain_q[TOP-1:0], async_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      last_q  <= 1'b0;
    end else begin
      chain_q <= chain_d;
      last_q  <= chain_q[TOP];
    end
  end

  assign rise_o = chain_q[TOP] & ~last_q;
  assign fall_o = ~chain_q[TOP] & last_q;
endmodule

// File: rtl/bsq_period_track.sv
module bsq_period_track
  import bus_slave_seq_pkg::*;
#(
  parameter int unsigned CW         = 8,
  parameter int unsigned DEF_PERIOD = 60,
  parameter int unsigned CTL_NUM    = 15,
  parameter int unsigned DRV_NUM    = 26,
  parameter int unsigned WR_NUM     = 30,
  parameter int unsigned GUARD      = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rise,
  input  logic          fall,
  output logic [CW-1:0] phase_o,
  output logic [CW-1:0] ctl_off_o,
  output logic [CW-1:0] drv_off_o,
  output logic [CW-1:0] wr_off_o,
  output logic          serve_o
);
  localparam logic [CW-1:0] PH_MAX   = '1;
  localparam int unsigned   DEF_FALL = DEF_PERIOD / 2;
  localparam int unsigned   NPT      = 3;
  localparam int unsigned   NUMS [NPT] = '{CTL_NUM, DRV_NUM, WR_NUM};

  logic [CW-1:0] phase_q, phase_d;
  logic [CW-1:0] fall_q, fall_d;
  logic          seen_q, seen_d;
  logic          serve_q, serve_d;
  logic [CW-1:0] offs [NPT];

  always_comb begin
    phase_d = phase_q;
    if (rise)                  phase_d = CW'(1);
    else if (phase_q != PH_MAX) phase_d = phase_q + 1'b1;
    fall_d  = fall ? phase_q : fall_q;
    seen_d  = seen_q | rise;
    serve_d = rise ? seen_q : serve_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      fall_q  <= CW'(DEF_FALL);
      seen_q  <= 1'b0;
      serve_q <= 1'b0;
    end else begin
      phase_q <= phase_d;
      fall_q  <= fall_d;
      seen_q  <= seen_d;
      serve_q <= serve_d;
    end
  end

  for (genvar g = 0; g < NPT; g++) begin : g_point
    logic [CW-1:0] off_q, off_d;
    logic          load_en;
    assign load_en = rise & seen_q;
    always_comb begin
      off_d = off_q;
      if (load_en) off_d = CW'(place_point(32'(phase_q), NUMS[g], 32'(fall_q), GUARD));
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) off_q <= CW'(place_point(DEF_PERIOD, NUMS[g], DEF_FALL, GUARD));
      else        off_q <= off_d;
    end
    assign offs[g] = off_q;
  end

  assign phase_o   = phase_q;
  assign ctl_off_o = offs[0];
  assign drv_off_o = offs[1];
  assign wr_off_o  = offs[2];
  assign serve_o   = serve_q;
endmodule

// File: rtl/bsq_cycle_fsm.sv
module bsq_cycle_fsm
  import bus_slave_seq_pkg::*;
#(
  parameter int unsigned AW = 5,
  parameter int unsigned DW = 8,
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rise,
  input  logic          fall,
  input  logic          serve,
  input  logic [CW-1:0] phase,
  input  logic [CW-1:0] ctl_off,
  input  logic [CW-1:0] drv_off,
  input  logic [CW-1:0] wr_off,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          bus_sel,
  input  logic          bus_rd_wr_n,
  input  logic [DW-1:0] reg_rdata,
  output logic [DW-1:0] bus_rdata,
  output logic          bus_oe,
  output logic          req_valid,
  output logic          req_write,
  output logic [AW-1:0] req_addr,
  output logic [DW-1:0] req_wdata
);
  sq_state_e     st_q, st_d;
  logic          oe_q, oe_d;
  logic          rv_q, rv_d;
  logic          rw_q, rw_d;
  logic [AW-1:0] ra_q, ra_d;
  logic [DW-1:0] rd_q, rd_d;
  logic [DW-1:0] dat_q, dat_d;
  logic [DW-1:0] out_q, out_d;

  always_comb begin
    st_d  = st_q;
    oe_d  = oe_q;
    rv_d  = 1'b0;
    rw_d  = rw_q;
    ra_d  = ra_q;
    rd_d  = rd_q;
    dat_d = dat_q;
    out_d = out_q;
    if (rise) begin
      st_d = SQ_ARM;
      oe_d = 1'b0;
    end else if (fall) begin
      st_d = SQ_IDLE;
      oe_d = 1'b0;
    end else begin
      case (st_q)
        SQ_ARM: begin
          if (phase >= ctl_off) begin
            if (!serve || !bus_sel) begin
              st_d = SQ_IDLE;
            end else begin
              ra_d = bus_addr;
              rw_d = ~bus_rd_wr_n;
              if (bus_rd_wr_n) begin
                rv_d = 1'b1;
                st_d = SQ_READ;
              end else begin
                st_d = SQ_WRITE;
              end
            end
          end
        end
        SQ_READ: begin
          if (rv_q) begin
            dat_d = reg_rdata;
          end else if (phase >= drv_off) begin
            oe_d  = 1'b1;
            out_d = dat_q;
          end
        end
        SQ_WRITE: begin
          if (phase >= wr_off) begin
            rd_d = bus_wdata;
            rv_d = 1'b1;
            st_d = SQ_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SQ_IDLE;
      oe_q  <= 1'b0;
      rv_q  <= 1'b0;
      rw_q  <= 1'b0;
      ra_q  <= '0;
      rd_q  <= '0;
      dat_q <= '0;
      out_q <= '0;
    end else begin
      st_q  <= st_d;
      oe_q  <= oe_d;
      rv_q  <= rv_d;
      rw_q  <= rw_d;
      ra_q  <= ra_d;
      rd_q  <= rd_d;
      dat_q <= dat_d;
      out_q <= out_d;
    end
  end

  assign bus_rdata = out_q;
  assign bus_oe    = oe_q;
  assign req_valid = rv_q;
  assign req_write = rw_q;
  assign req_addr  = ra_q;
  assign req_wdata = rd_q;
endmodule

// File: rtl/bus_slave_seq.sv
module bus_slave_seq #(
  parameter int unsigned AW          = 5,
  parameter int unsigned DW          = 8,
  parameter int unsigned CW          = 8,
  parameter int unsigned DEF_PERIOD  = 60,
  parameter int unsigned CTL_NUM     = 15,
  parameter int unsigned DRV_NUM     = 26,
  parameter int unsigned WR_NUM      = 30,
  parameter int unsigned GUARD       = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_clk,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          bus_sel,
  input  logic          bus_rd_wr_n,
  output logic [DW-1:0] bus_rdata,
  output logic          bus_oe,
  output logic          req_valid,
  output logic          req_write,
  output logic [AW-1:0] req_addr,
  output logic [DW-1:0] req_wdata,
  input  logic [DW-1:0] reg_rdata
);
  logic          rst_meta_q, rst_sync_q;
  logic          edge_rise, edge_fall, serve;
  logic [CW-1:0] phase, ctl_off, drv_off, wr_off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  bsq_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_sync_q), .async_in(bus_clk),
    .rise_o(edge_rise), .fall_o(edge_fall)
  );

  bsq_period_track #(
    .CW(CW), .DEF_PERIOD(DEF_PERIOD), .CTL_NUM(CTL_NUM),
    .DRV_NUM(DRV_NUM), .WR_NUM(WR_NUM), .GUARD(GUARD)
  ) u_track (
    .clk(clk), .rst_n(rst_sync_q), .rise(edge_rise), .fall(edge_fall),
    .phase_o(phase), .ctl_off_o(ctl_off), .drv_off_o(drv_off),
    .wr_off_o(wr_off), .serve_o(serve)
  );

  bsq_cycle_fsm #(.AW(AW), .DW(DW), .CW(CW)) u_fsm (
    .clk(clk), .rst_n(rst_sync_q), .rise(edge_rise), .fall(edge_fall),
    .serve(serve), .phase(phase), .ctl_off(ctl_off), .drv_off(drv_off),
    .wr_off(wr_off), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_sel(bus_sel), .bus_rd_wr_n(bus_rd_wr_n), .reg_rdata(reg_rdata),
    .bus_rdata(bus_rdata), .bus_oe(bus_oe), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata)
  );
endmodule

// File: rtl/bus_slave_seq_chk.sv
module bus_slave_seq_chk #(
  parameter int unsigned DW = 8,
  parameter int unsigned CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          edge_rise,
  input logic          edge_fall,
  input logic          serve,
  input logic          bus_oe,
  input logic [DW-1:0] bus_rdata,
  input logic          req_valid,
  input logic [CW-1:0] ctl_off
);
  logic [1:0] req_cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            req_cnt_q <= '0;
    else if (edge_rise)                    req_cnt_q <= '0;
    else if (req_valid && req_cnt_q != 2'd3) req_cnt_q <= req_cnt_q + 2'd1;
  end

  p_req_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> !req_valid);

  p_one_req_per_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_cnt_q == 2'd0));

  p_oe_off_after_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    edge_fall |=> !bus_oe);

  p_oe_off_after_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    edge_rise |=> !bus_oe);

  p_rdata_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe && $past(bus_oe)) |-> $stable(bus_rdata));

  p_unserved_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !serve |-> (!req_valid && !bus_oe));

  p_offset_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !edge_rise |=> $stable(ctl_off));
endmodule

bind bus_slave_seq bus_slave_seq_chk #(.DW(DW), .CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_sync_q), .edge_rise(edge_rise), .edge_fall(edge_fall),
  .serve(serve), .bus_oe(bus_oe), .bus_rdata(bus_rdata),
  .req_valid(req_valid), .ctl_off(ctl_off)
);

// File: tb/bus_slave_seq_tb_top.sv
module bus_slave_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 5;
  localparam int DW = 8;
  localparam int CW = 8;
  localparam int DEFP = 60;
  localparam int CTLN = 15;
  localparam int DRVN = 26;
  localparam int WRN  = 30;
  localparam int GRD  = 3;
  localparam int PMAX = (1 << CW) - 1;

  logic          clk, rst_n, bus_clk, bus_sel, bus_rd_wr_n;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata, req_wdata, reg_rdata;
  logic          bus_oe, req_valid, req_write;
  logic [AW-1:0] req_addr;

  bus_slave_seq dut_i (
    .clk(clk), .rst_n(rst_n), .bus_clk(bus_clk), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_sel(bus_sel), .bus_rd_wr_n(bus_rd_wr_n),
    .bus_rdata(bus_rdata), .bus_oe(bus_oe), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .reg_rdata(reg_rdata)
  );

  function automatic logic [DW-1:0] rd_fn(logic [AW-1:0] a);
    return 8'h3C ^ {a, 3'b101};
  endfunction

  assign reg_rdata = rd_fn(req_addr);

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  int    n_cmp = 0;
  int    n_bad = 0;
  int    n_req = 0;
  int    n_oe  = 0;
  bit    comparing = 0;
  string ctx = "R11";

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s (%s) actual=%0h expected=%0h at %0t", tag, ctx, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // Offset placement per R3
  function automatic int pt(int p, int num, int f);
    int v, lim;
    v   = (p * num) / 64;
    lim = (f > GRD) ? f - GRD : 1;
    if (v > lim) v = lim;
    if (v < 1) v = 1;
    return v;
  endfunction

  // Behavioural reference model, advanced on every clock edge
  int h1, h2, h3, ph, seen, serve, fallp, oc, od, ow, st;
  int m_oe, m_rdo, m_req, m_wr, m_addr, m_wdata, m_rdat;

  always @(posedge clk or negedge rst_n) begin : model
    int r, fl, oldph, oldreq;
    if (!rst_n) begin
      h1 = 0; h2 = 0; h3 = 0; ph = 0; seen = 0; serve = 0;
      fallp = DEFP / 2;
      oc = pt(DEFP, CTLN, fallp); od = pt(DEFP, DRVN, fallp); ow = pt(DEFP, WRN, fallp);
      st = 0; m_oe = 0; m_rdo = 0; m_req = 0; m_wr = 0; m_addr = 0; m_wdata = 0; m_rdat = 0;
    end else begin
      // R1: two-stage delay line plus one-cycle edge comparison
      r  = (h2 == 1 && h3 == 0) ? 1 : 0;
      fl = (h2 == 0 && h3 == 1) ? 1 : 0;
      h3 = h2; h2 = h1; h1 = int'(bus_clk);
      oldph = ph; oldreq = m_req; m_req = 0;
      if (r == 1) begin
        ph = 1;
        if (seen == 1) begin  // R2, R3
          oc = pt(oldph, CTLN, fallp); od = pt(oldph, DRVN, fallp); ow = pt(oldph, WRN, fallp);
        end
        serve = seen; seen = 1;  // R4
        st = 1; m_oe = 0;
      end else begin
        ph = (oldph >= PMAX) ? PMAX : oldph + 1;
        if (fl == 1) begin  // R9
          fallp = oldph; st = 0; m_oe = 0;
        end else begin
          case (st)
            1: if (oldph >= oc) begin
                 if (serve == 0 || bus_sel == 1'b0) st = 0;  // R8
                 else begin
                   m_addr = int'(bus_addr);
                   m_wr   = bus_rd_wr_n ? 0 : 1;
                   if (bus_rd_wr_n) begin m_req = 1; st = 2; end
                   else st = 3;
                 end
               end
            2: if (oldreq == 1) m_rdat = int'(rd_fn(AW'(m_addr)));
               else if (oldph >= od) begin m_oe = 1; m_rdo = m_rdat; end
            3: if (oldph >= ow) begin m_wdata = int'(bus_wdata); m_req = 1; st = 0; end
            default: ;
          endcase
        end
      end
    end
  end

  always @(negedge clk) begin
    if (req_valid) n_req++;
    if (bus_oe) n_oe++;
    if (comparing) begin
      chk("R6", int'(bus_oe), m_oe);
      chk((m_wr == 1) ? "R7" : "R5", int'(req_valid), m_req);
      if (m_req == 1 && req_valid) begin
        chk((m_wr == 1) ? "R7" : "R5", int'(req_write), m_wr);
        chk("R8", int'(req_addr), m_addr);
        if (m_wr == 1) chk("R7", int'(req_wdata), m_wdata);
      end
      if (m_oe == 1 && bus_oe) chk("R6", int'(bus_rdata), m_rdo);
    end
  end

  task automatic bus_cyc(int hi, int lo, bit sel, bit rd, int addr, int wd, bit late);
    bus_addr = AW'(addr); bus_wdata = DW'(wd); bus_sel = sel; bus_rd_wr_n = rd;
    bus_clk = 1'b1;
    for (int i = 0; i < hi; i++) begin
      @(negedge clk);
      if (late && i == hi - 3) bus_addr = ~AW'(addr);
    end
    bus_clk = 1'b0;
    repeat (lo) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    int q0, o0;
    rst_n = 1'b0; bus_clk = 1'b0; bus_sel = 1'b0; bus_rd_wr_n = 1'b1;
    bus_addr = '0; bus_wdata = '0;
    repeat (4) @(negedge clk);
    ctx = "R11";
    chk("R11", int'(bus_oe), 0);
    chk("R11", int'(req_valid), 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    comparing = 1;
    chk("R11", int'(bus_oe), 0);
    chk("R11", int'(req_valid), 0);

    ctx = "R4";  // first rising edge never served
    q0 = n_req; o0 = n_oe;
    bus_cyc(30, 30, 1, 1, 3, 0, 0);
    chk("R4", n_req - q0, 0);
    chk("R4", n_oe - o0, 0);

    ctx = "R1 R5";  // reads at a 60-cycle period
    bus_cyc(30, 30, 1, 1, 5, 0, 0);
    bus_cyc(30, 30, 1, 1, 17, 0, 0);
    ctx = "R7";
    bus_cyc(30, 30, 1, 0, 9, 8'hA5, 0);
    bus_cyc(30, 30, 1, 0, 30, 8'h5A, 0);

    ctx = "R8";  // unselected cycles, late address change
    q0 = n_req; o0 = n_oe;
    bus_cyc(30, 30, 0, 1, 4, 0, 0);
    bus_cyc(30, 30, 0, 0, 4, 8'h11, 0);
    chk("R8", n_req - q0, 0);
    chk("R8", n_oe - o0, 0);
    bus_cyc(30, 30, 1, 0, 12, 8'h33, 1);

    ctx = "R9";  // fast cycle with stale offsets: request yes, drive cancelled
    q0 = n_req; o0 = n_oe;
    bus_cyc(17, 17, 1, 1, 6, 0, 0);
    chk("R9", n_req - q0, 1);
    chk("R9", n_oe - o0, 0);

    ctx = "R3";  // adapted offsets at the fast rate
    bus_cyc(17, 17, 1, 1, 6, 0, 0);
    bus_cyc(17, 17, 1, 0, 7, 8'hC3, 0);
    bus_cyc(16, 18, 1, 1, 21, 0, 0);
    bus_cyc(16, 18, 1, 0, 22, 8'h7E, 0);

    ctx = "R9";  // shrunken high phase cancels the write point
    bus_cyc(40, 20, 1, 0, 2, 8'h01, 0);
    bus_cyc(40, 20, 1, 0, 3, 8'h02, 0);
    q0 = n_req;
    bus_cyc(22, 38, 1, 0, 8, 8'h99, 0);
    chk("R9", n_req - q0, 0);

    ctx = "R2";  // saturated period measurement
    bus_cyc(150, 150, 1, 1, 10, 0, 0);
    bus_cyc(150, 150, 1, 1, 11, 0, 0);
    q0 = n_req;
    bus_cyc(30, 30, 1, 1, 12, 0, 0);
    chk("R2", n_req - q0, 0);
    ctx = "R10";
    bus_cyc(30, 30, 1, 1, 13, 0, 0);
    bus_cyc(25, 25, 1, 0, 14, 8'hE7, 0);
    bus_cyc(28, 22, 1, 1, 15, 0, 0);
    bus_cyc(28, 22, 1, 1, 16, 0, 0);
    repeat (10) @(negedge clk);
    summary();
    $finish;
  end
endmodule